// File: doc/BRIEF.md
# Table-Sequenced Serial Word Formatter

The formatter converts parallel 16-bit results from up to four processing channels into a bit-serial stream, MSB first. It drives a serial clock derived from the system clock and a sync strobe. An eight-entry sequence table sets the order of the words in a frame. Each entry names a channel and a data type:

- in-phase (I)
- quadrature (Q)
- magnitude
- phase
- frequency
- gain
- zeros

One frame can therefore interleave several channels and several kinds of data in any order.

A frame starts on a one-cycle start pulse and runs until an entry carrying the end flag has been sent, or until the table runs out. Words are taken from the data ports at the start of each word, so upstream logic must hold a word's value from the word's load edge until that word has been sent.

An optional second serial output sends the next table entry in the same word slot as the primary output. This halves the length of a frame. The sync strobe can mark:

- every word,
- only the frame start, or
- the bit period ahead of each word.

The polarities of the strobe and of the serial clock are programmable. Configuration inputs are expected to stay constant while a frame is in progress.

Top module: `serfmt`

## Requirements
- R1: A word is 16 bits, sent MSB first on `sd1`. Each bit lasts N system clocks, where N = 2^`div_sel` for `div_sel` 0 to 4; a `div_sel` above 4 acts as 4. With no lead bit, a frame of n word slots keeps `busy` high for exactly n*16*N cycles. With a lead bit it keeps `busy` high for (1+n*16)*N cycles. `sd1` and `sd2` are 0 whenever `busy` is low.
- R2: The serial clock without inversion is low in the first N/2 clocks of each bit and high in the last N/2. When N=1 it is the inverted system clock. It is low while idle. `sclk_inv`=1 inverts `sclk` at all times.
- R3: Table entry k sits at `seq_tbl[6k+5:6k]`. Bits [1:0] hold the channel, bits [4:2] hold the type, and bit 5 is the end flag. The word slots of a frame take entries in increasing order from entry 0. The frame ends after the slot that holds a flagged entry, or after entry 7.
- R4: The type codes are 0 = I, 1 = Q, 2 = magnitude, 3 = phase, 4 = frequency and 5 = gain. Type c of channel h sends bits [16h+15:16h] of the matching data port. Types 6 and 7 send an all-zero word.
- R5: With `sync_pos`=0, the strobe is active for the whole first bit of every word.
- R6: With `sync_pos`=1, the strobe is active only during the first bit of the first word of a frame.
- R7: With `sync_pos`=2, each frame begins with one lead bit period in which the strobe is active and `sd1`/`sd2` are 0. After that, the strobe is active during the last bit of every word slot that is followed by another slot.
- R8: With `sync_pos`=3, the strobe is never active. Active means 1 when `sync_inv`=0 and 0 when `sync_inv`=1.
- R9: With `aux_en`=1, a word slot sends entry k on `sd1` and entry k+1 on `sd2`, and the next slot starts at entry k+2. If entry k carries the end flag, `sd2` sends zeros. The frame ends after a slot in which either entry carries the end flag. With `aux_en`=0, `sd2` stays 0.
- R10: A start pulse while idle makes `busy` high on the next cycle. A start pulse in any cycle where `busy` is high is ignored: the frame contents and length are unchanged and no new frame follows. Such a pulse also sets `overrun`, which stays set until reset.
- R11: During reset, `busy`, `sd1`, `sd2` and `overrun` are 0, `sync` equals `sync_inv` and `sclk` equals `sclk_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| frame_go | input | 1 | One-cycle frame start pulse |
| d_i | input | 64 | I words, 16 bits per channel |
| d_q | input | 64 | Q words, 16 bits per channel |
| d_mag | input | 64 | Magnitude words |
| d_phs | input | 64 | Phase words |
| d_frq | input | 64 | Frequency words |
| d_gain | input | 64 | Gain words |
| seq_tbl | input | 48 | Eight 6-bit sequence entries |
| div_sel | input | 3 | Serial clock divide select |
| aux_en | input | 1 | Enable second serial output |
| sync_pos | input | 2 | Sync placement mode |
| sclk_inv | input | 1 | Invert serial clock |
| sync_inv | input | 1 | Invert sync strobe |
| sclk | output | 1 | Serial clock |
| sd1 | output | 1 | Primary serial data |
| sd2 | output | 1 | Auxiliary serial data |
| sync | output | 1 | Sync strobe |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky ignored-start flag |

## Verification
The two functions that can land on the same clock edge are the end of a frame and a new start pulse. In that cycle the last bit period closes while `busy` is still high, so the formatter must not begin a new frame and must raise `overrun` instead. The bench provokes this by pulsing `frame_go` in the final busy cycle of a frame. It then checks three things:
- the frame was sent completely,
- `busy` falls and stays low,
- `overrun` is set.

A second pulse placed mid-frame is judged in the same way, by comparing every serial word and the frame length against the model.

// File: rtl/serfmt.sv
module serfmt #(
  parameter int W = 16,
  parameter int NCH = 4,
  parameter int NSLOT = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 frame_go,
  input  logic [NCH*W-1:0]                     d_i,
  input  logic [NCH*W-1:0]                     d_q,
  input  logic [NCH*W-1:0]                     d_mag,
  input  logic [NCH*W-1:0]                     d_phs,
  input  logic [NCH*W-1:0]                     d_frq,
  input  logic [NCH*W-1:0]                     d_gain,
  input  logic [NSLOT*($clog2(NCH)+4)-1:0]     seq_tbl,
  input  logic [2:0]                           div_sel,
  input  logic                                 aux_en,
  input  logic [1:0]                           sync_pos,
  input  logic                                 sclk_inv,
  input  logic                                 sync_inv,
  output logic                                 sclk,
  output logic                                 sd1,
  output logic                                 sd2,
  output logic                                 sync,
  output logic                                 busy,
  output logic                                 overrun
);
  localparam int CHW = $clog2(NCH);
  localparam int EW  = CHW + 4;
  localparam int SW  = $clog2(NSLOT) + 1;
  localparam int BW  = $clog2(W);

  logic [SW-1:0] slot, ld_idx, step;
  logic [BW-1:0] bitc;
  logic [3:0]    pcnt;
  logic          lead, la, lb;
  logic [W-1:0]  sh1, sh2;
  logic [2:0]    dsel;
  logic [4:0]    nper;
  logic          bend, fend, lastbit, sraw;
  logic [EW-1:0] ea, eb;
  logic [W-1:0]  wa, wb;

  function automatic logic [EW-1:0] entry_at(input logic [SW-1:0] idx);
    if (int'(idx) < NSLOT) return seq_tbl[int'(idx)*EW +: EW];
    return {1'b1, 3'd6, {CHW{1'b0}}};
  endfunction

  function automatic logic [W-1:0] pick(input logic [EW-1:0] e);
    int c;
    c = int'(e[CHW-1:0]);
    case (e[CHW+2:CHW])
      3'd0:    return d_i[c*W +: W];
      3'd1:    return d_q[c*W +: W];
      3'd2:    return d_mag[c*W +: W];
      3'd3:    return d_phs[c*W +: W];
      3'd4:    return d_frq[c*W +: W];
      3'd5:    return d_gain[c*W +: W];
      default: return '0;
    endcase
  endfunction

  assign dsel    = (div_sel > 3'd4) ? 3'd4 : div_sel;
  assign nper    = 5'd1 << dsel;
  assign bend    = {1'b0, pcnt} == (nper - 5'd1);
  assign step    = aux_en ? SW'(2) : SW'(1);
  assign lastbit = !lead && (bitc == BW'(W-1));
  assign fend    = la || lb || ((int'(slot) + int'(step)) >= NSLOT);
  assign ld_idx  = busy ? slot + step : '0;
  assign ea      = entry_at(ld_idx);
  assign eb      = entry_at(ld_idx + SW'(1));
  assign wa      = pick(ea);
  assign wb      = (aux_en && !ea[EW-1]) ? pick(eb) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; overrun <= 1'b0; lead <= 1'b0;
      slot <= '0; bitc <= '0; pcnt <= '0;
      sh1 <= '0; sh2 <= '0; la <= 1'b0; lb <= 1'b0;
    end else begin
      if (frame_go && busy) overrun <= 1'b1;
      if (!busy) begin
        if (frame_go) begin
          busy <= 1'b1; slot <= '0; bitc <= '0; pcnt <= '0;
          lead <= (sync_pos == 2'd2);
          sh1 <= wa; sh2 <= wb;
          la <= ea[EW-1];
          lb <= aux_en && !ea[EW-1] && eb[EW-1];
        end
      end else begin
        pcnt <= bend ? 4'd0 : pcnt + 4'd1;
        if (bend) begin
          if (lead) lead <= 1'b0;
          else if (lastbit) begin
            bitc <= '0;
            if (fend) busy <= 1'b0;
            else begin
              slot <= ld_idx;
              sh1 <= wa; sh2 <= wb;
              la <= ea[EW-1];
              lb <= aux_en && !ea[EW-1] && eb[EW-1];
            end
          end else begin
            bitc <= bitc + BW'(1);
            sh1 <= sh1 << 1;
            sh2 <= sh2 << 1;
          end
        end
      end
    end
  end

  assign sd1 = busy && !lead && sh1[W-1];
  assign sd2 = busy && !lead && sh2[W-1];

  always_comb begin
    case (sync_pos)
      2'd0:    sraw = busy && !lead && bitc == '0;
      2'd1:    sraw = busy && !lead && bitc == '0 && slot == '0;
      2'd2:    sraw = busy && (lead || (lastbit && !fend));
      default: sraw = 1'b0;
    endcase
  end

  assign sync = sraw ^ sync_inv;
  assign sclk = (busy && ((dsel == 3'd0) ? !clk : ({1'b0, pcnt} >= (nper >> 1)))) ^ sclk_inv;

  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go && !busy |=> busy && bitc == '0 && pcnt == 4'd0);
  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go && busy |=> overrun);
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_aux_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !aux_en |-> !sd2);
  p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && pcnt != 4'd0 |-> $stable(sd1) && $stable(sd2));
endmodule

// File: tb/serfmt_test.sv
`timescale 1ns/1ps
module serfmt_test;
  logic clk = 0, rst_n = 0, frame_go = 0;
  logic [63:0] d_i, d_q, d_mag, d_phs, d_frq, d_gain;
  logic [47:0] seq_tbl = '0;
  logic [2:0] div_sel = 0;
  logic aux_en = 0, sclk_inv = 0, sync_inv = 0;
  logic [1:0] sync_pos = 0;
  logic sclk, sd1, sd2, sync, busy, overrun;
  int checks = 0, errors = 0;
  bit done = 0;
  logic c1 [0:4200];
  logic c2 [0:4200];
  logic cs [0:4200];
  logic ck [0:4200];
  logic cb [0:4200];

  always #2.5 clk = ~clk;

  serfmt uut (.clk(clk), .rst_n(rst_n), .frame_go(frame_go), .d_i(d_i), .d_q(d_q),
    .d_mag(d_mag), .d_phs(d_phs), .d_frq(d_frq), .d_gain(d_gain), .seq_tbl(seq_tbl),
    .div_sel(div_sel), .aux_en(aux_en), .sync_pos(sync_pos), .sclk_inv(sclk_inv),
    .sync_inv(sync_inv), .sclk(sclk), .sd1(sd1), .sd2(sd2), .sync(sync), .busy(busy),
    .overrun(overrun));

  localparam logic [55:0] VEC [0:7] = '{
    {30'b0, 6'b1_010_10, 6'b0_001_01, 6'b0_000_00, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0},
    {24'b0, 6'b1_110_10, 6'b0_101_01, 6'b0_100_00, 6'b0_011_11, 3'd1, 1'b0, 2'd1, 1'b1, 1'b0},
    {24'b0, 6'b1_001_01, 6'b0_000_01, 6'b0_001_00, 6'b0_000_00, 3'd2, 1'b1, 2'd0, 1'b0, 1'b0},
    {30'b0, 6'b1_100_01, 6'b0_101_10, 6'b0_010_11, 3'd4, 1'b1, 2'd2, 1'b0, 1'b1},
    {6'b0_101_11, 6'b0_100_10, 6'b0_011_01, 6'b0_010_00, 6'b0_001_11, 6'b0_000_10,
     6'b0_111_01, 6'b0_010_11, 3'd3, 1'b0, 2'd3, 1'b1, 1'b1},
    {42'b0, 6'b1_000_10, 3'd0, 1'b1, 2'd2, 1'b0, 1'b0},
    {36'b0, 6'b1_111_01, 6'b0_001_11, 3'd6, 1'b0, 2'd2, 1'b0, 1'b0},
    {6'b0_000_11, 6'b0_001_10, 6'b0_010_01, 6'b0_011_00, 6'b0_100_11, 6'b0_101_10,
     6'b0_000_01, 6'b0_001_00, 3'd1, 1'b1, 2'd1, 1'b0, 1'b0}
  };

  function automatic logic [15:0] dval(input int ty, input int ch);
    return {4'(ty*3+ch+2), 4'(15-ty-ch), 4'(ty+ch*4), 4'(ch*5+ty+9)};
  endfunction

  function automatic logic [5:0] ent(input logic [47:0] t, input int i);
    if (i < 8) return t[i*6 +: 6];
    return 6'b1_110_00;
  endfunction

  function automatic logic [15:0] bval(input logic [5:0] e);
    if (int'(e[4:2]) >= 6) return 16'h0;
    return dval(int'(e[4:2]), int'(e[1:0]));
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_frame(input logic [55:0] v, input int g);
    logic [47:0] t;
    logic [15:0] wa [0:7];
    logic [15:0] wb [0:7];
    int nw, idx, st, n, L, T, dv, serr, e1;
    logic ax, la, lb, si, ci, ex;
    logic [1:0] ps;
    logic [5:0] ea, eb;
    logic [15:0] g1, g2;
    t = v[55:8]; dv = int'(v[7:5]); ax = v[4]; ps = v[3:2]; si = v[1]; ci = v[0];
    if (dv > 4) dv = 4;
    n = 1 << dv; L = (ps == 2'd2) ? 1 : 0; st = ax ? 2 : 1;
    idx = 0; nw = 0;
    for (int s = 0; s < 8; s++) begin
      ea = ent(t, idx); la = ea[5]; wa[s] = bval(ea);
      if (ax && !la) begin eb = ent(t, idx+1); wb[s] = bval(eb); lb = eb[5]; end
      else begin wb[s] = 16'h0; lb = 0; end
      nw++;
      if (la || lb || idx + st >= 8) break;
      idx += st;
    end
    T = (L + nw*16) * n;
    if (g == -2) g = T - 1;
    seq_tbl = t; div_sel = v[7:5]; aux_en = ax; sync_pos = ps; sync_inv = si; sclk_inv = ci;
    frame_go = 1;
    @(negedge clk);
    for (int k = 0; k <= T; k++) begin
      c1[k] = sd1; c2[k] = sd2; cs[k] = sync; ck[k] = sclk; cb[k] = busy;
      frame_go = (k == g);
      @(negedge clk);
    end
    frame_go = 0;
    serr = 0;
    if (L == 1) begin
      if (cs[0] !== (1'b1 ^ si)) serr++;
      if (c1[0] !== 1'b0 || c2[0] !== 1'b0) serr++;
    end
    for (int w = 0; w < nw; w++) begin
      for (int b = 0; b < 16; b++) begin
        e1 = (L + w*16 + b) * n;
        g1[15-b] = c1[e1]; g2[15-b] = c2[e1];
        case (ps)
          2'd0: ex = (b == 0);
          2'd1: ex = (w == 0 && b == 0);
          2'd2: ex = (b == 15 && w != nw-1);
          default: ex = 0;
        endcase
        if (cs[e1] !== (ex ^ si)) serr++;
      end
      chk($sformatf("R1 R3 R4 sd1 word %0d", w), {16'h0, g1}, {16'h0, wa[w]});
      chk($sformatf("R9 sd2 word %0d", w), {16'h0, g2}, {16'h0, wb[w]});
    end
    case (ps)
      2'd0: chk("R5 sync every word", serr, 0);
      2'd1: chk("R6 sync frame start", serr, 0);
      2'd2: chk("R7 sync lead and pre-word", serr, 0);
      default: chk("R8 sync off", serr, 0);
    endcase
    serr = 0;
    for (int j = 0; j < n; j++) begin
      ex = (n == 1) ? 1'b1 : (j >= n/2);
      if (ck[L*n + j] !== (ex ^ ci)) serr++;
    end
    chk("R2 sclk shape", serr, 0);
    chk("R1 frame length", {30'b0, cb[T-1], cb[T]}, 32'b10);
    @(negedge clk);
    chk("R2 sclk idle", {31'b0, sclk}, {31'b0, ci});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      d_i[c*16 +: 16] = dval(0, c);   d_q[c*16 +: 16] = dval(1, c);
      d_mag[c*16 +: 16] = dval(2, c); d_phs[c*16 +: 16] = dval(3, c);
      d_frq[c*16 +: 16] = dval(4, c); d_gain[c*16 +: 16] = dval(5, c);
    end
    sync_inv = 1; sclk_inv = 1;
    repeat (3) @(negedge clk);
    chk("R11 reset busy", {31'b0, busy}, 0);
    chk("R11 reset data", {30'b0, sd1, sd2}, 0);
    chk("R11 reset overrun", {31'b0, overrun}, 0);
    chk("R11 reset sync", {31'b0, sync}, 1);
    chk("R11 reset sclk", {31'b0, sclk}, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      run_frame(VEC[i], -1);
      repeat (3) @(negedge clk);
    end
    chk("R10 no overrun yet", {31'b0, overrun}, 0);
    run_frame(VEC[0], 20);
    chk("R10 mid-frame pulse sets overrun", {31'b0, overrun}, 1);
    repeat (5) @(negedge clk);
    chk("R10 overrun sticky", {31'b0, overrun}, 1);
    rst_n = 0;
    @(negedge clk);
    chk("R11 reset clears overrun", {31'b0, overrun}, 0);
    rst_n = 1;
    @(negedge clk);
    run_frame(VEC[5], -2);
    chk("R10 last-cycle pulse sets overrun", {31'b0, overrun}, 1);
    repeat (4) @(negedge clk);
    chk("R10 no restart after ignored pulse", {31'b0, busy}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule